// File: doc/BRIEF.md
# Variable-Length Instruction Framer and Decoder

This block sits between program memory and the execute stage of a small CPU whose opcodes are one byte wide and whose operands are 16 bits. Program bytes arrive one at a time on a valid/ready interface. The block reads the first byte of each instruction and works out from it how many bytes the instruction holds: one, two or three. It gathers any immediate bytes that follow and presents one complete instruction per valid/ready transfer on its output.

Each output instruction carries the raw opcode byte, a class code, the length, an illegal-opcode flag, the address of its first byte, and the operand widened to the operand width. Some opcodes pack a 4-bit immediate into their low nibble. An escape range gives these packed forms longer versions with a byte or a word immediate. Some byte immediates are sign-extended and others are zero-extended, and the opcode decides which.

A synchronous flush, used for example after a taken branch, discards any half-gathered instruction and any output that has not yet been accepted. It also restarts address counting at a new value.

Top module: `vfd_fetch_decode`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the first instruction received reports address `RESET_ADDR` (default 0).
- R2: Length rules, reported on `out_len` as 1, 2 or 3:
  - The following are 3 bytes long: 0x02–0x05, 0x49–0x4E, 0x5A–0x5B, every even opcode in 0x10–0x2A and 0x5C–0x6C, and the even opcodes 0xF4–0xFC.
  - The following are 2 bytes long: 0x2E, 0x2F, 0x52–0x54, every odd opcode in 0x11–0x2B and 0x5D–0x6D, and the odd opcodes 0xF5–0xFD.
  - Every other opcode is 1 byte long.
- R3: A 3-byte instruction has class 1. Its operand is the third byte times 256 plus the second byte, zero-extended.
- R4: For a 2-byte instruction, the operand is the second byte:
  - It is sign-extended, with class 3, for the odd opcodes 0x17–0x21 and for 0xF9, 0xFB and 0xFD.
  - In every other 2-byte instruction it is zero-extended, with class 2.
- R5: Opcodes 0xA0–0xEF are 1 byte long and take their operand from the low nibble of the opcode. The nibble is zero-extended (0..15, class 4) for 0xA0–0xBF and sign-extended (−8..7, class 5) for 0xC0–0xEF.
- R6: The remaining legal 1-byte opcodes have class 0 and operand 0. These are 0x00–0x01, 0x06–0x0F, 0x2C–0x2D, 0x30–0x48, 0x4F, 0x55–0x59 and 0x6E–0x79.
- R7: Opcodes 0x50, 0x51, 0x7A–0x9F, 0xF0–0xF3, 0xFE and 0xFF set `out_illegal`. They have class 7, length 1 and operand 0. All other opcodes clear `out_illegal`.
- R8: `out_addr` is the address of the opcode byte. Each following instruction starts at the previous address plus its length, wrapping modulo 2^ADDR_W.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` stays 0. No input byte is lost or duplicated.
- R10: While `flush` is 1, `in_ready` is 0. In the next cycle `out_valid` is 0, and any partly gathered bytes are discarded. The next opcode accepted after a flush reports address `flush_addr`.
- R11: `out_opcode` equals the first byte of the instruction as received, including the escape opcodes 0xF4–0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard state and restart at `flush_addr` |
| flush_addr | input | ADDR_W | Address of the next byte after a flush |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Program byte |
| out_valid | output | 1 | Complete instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_opcode | output | 8 | First byte of the instruction |
| out_class | output | 3 | Operand class code (0,1,2,3,4,5,7) |
| out_len | output | 2 | Instruction length in bytes |
| out_illegal | output | 1 | Opcode is undefined |
| out_operand | output | OPW | Operand widened to OPW bits |
| out_addr | output | ADDR_W | Address of the opcode byte |

## Verification
Some properties are checked on every cycle by assertions:
- The output holds steady under back-pressure, and a flush empties the output.
- An illegal opcode always comes out as a single byte with a zero operand.
- Only class 1 is three bytes long.
- Zero-extended byte operands and sign-extended nibble operands stay within their ranges.

Other properties only the bench scenarios can show:
- that each of the 256 opcodes gets the right length and extension;
- that low and high operand bytes land in the right places;
- that addresses step correctly and wrap;
- that no byte is lost when input gaps and output stalls interleave.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

   typedef enum logic [2:0] {
      CL_NONE     = 3'd0,
      CL_WORD     = 3'd1,
      CL_BYTE_ZX  = 3'd2,
      CL_BYTE_SX  = 3'd3,
      CL_QUICK_ZX = 3'd4,
      CL_QUICK_SX = 3'd5,
      CL_ILLEGAL  = 3'd7
   } instr_cls_e;

   typedef struct packed {
      logic [1:0] len;
      instr_cls_e cls;
   } op_info_t;

   // Length and operand class from the opcode byte alone.
   function automatic op_info_t classify(input logic [7:0] op);
      op_info_t r;
      r.len = 2'd1;
      r.cls = CL_NONE;
      if (op inside {[8'h02:8'h05], [8'h49:8'h4E], 8'h5A, 8'h5B}) begin
         r.len = 2'd3;
         r.cls = CL_WORD;
      end else if (op inside {8'h2E, 8'h2F, [8'h52:8'h54]}) begin
         r.len = 2'd2;
         r.cls = CL_BYTE_ZX;
      end else if (op inside {[8'h10:8'h2B], [8'h5C:8'h6D]}) begin
         // paired forms: even = word immediate, odd = byte immediate
         if (!op[0]) begin
            r.len = 2'd3;
            r.cls = CL_WORD;
         end else begin
            r.len = 2'd2;
            r.cls = (op inside {[8'h16:8'h21]}) ? CL_BYTE_SX : CL_BYTE_ZX;
         end
      end else if (op inside {[8'hA0:8'hEF]}) begin
         r.cls = (op >= 8'hC0) ? CL_QUICK_SX : CL_QUICK_ZX;
      end else if (op inside {[8'hF4:8'hFD]}) begin
         // escape range: long versions of the nibble-immediate groups
         if (!op[0]) begin
            r.len = 2'd3;
            r.cls = CL_WORD;
         end else begin
            r.len = 2'd2;
            r.cls = (op >= 8'hF8) ? CL_BYTE_SX : CL_BYTE_ZX;
         end
      end else if (!(op inside {8'h00, 8'h01, [8'h06:8'h0F], 8'h2C, 8'h2D,
                                [8'h30:8'h48], 8'h4F, [8'h55:8'h59],
                                [8'h6E:8'h79]})) begin
         r.cls = CL_ILLEGAL;
      end
      return r;
   endfunction

endpackage

// File: rtl/vfd_opdecode.sv
module vfd_opdecode
   import vfd_pkg::*;
(
   input  logic [7:0] op,
   output op_info_t   info
);

   always_comb begin
      info = classify(op);
   end

endmodule

// File: rtl/vfd_imm_ext.sv
module vfd_imm_ext
   import vfd_pkg::*;
#(
   parameter int OPW = 16
) (
   input  instr_cls_e     cls,
   input  logic [7:0]     op,
   input  logic [7:0]     lo,
   input  logic [7:0]     hi,
   output logic [OPW-1:0] val
);

   localparam int NIB_W = 4;

   logic [NIB_W-1:0] nib;
   assign nib = op[NIB_W-1:0];

   always_comb begin
      unique case (cls)
         CL_WORD:     val = OPW'({hi, lo});
         CL_BYTE_ZX:  val = OPW'(lo);
         CL_BYTE_SX:  val = OPW'($signed(lo));
         CL_QUICK_ZX: val = OPW'(nib);
         CL_QUICK_SX: val = OPW'($signed(nib));
         default:     val = '0;
      endcase
   end

endmodule

// File: rtl/vfd_collect.sv
module vfd_collect
   import vfd_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              in_valid,
   input  logic              in_ready,
   input  logic [7:0]        in_byte,
   input  op_info_t          dec_info,
   output logic              done,
   output logic [7:0]        cmp_op,
   output op_info_t          cmp_info,
   output logic [7:0]        cmp_lo,
   output logic [7:0]        cmp_hi,
   output logic [ADDR_W-1:0] cmp_addr
);

   localparam int PH_W = 2;

   logic [PH_W-1:0]   phase_q;
   logic [7:0]        op_q;
   logic [7:0]        lo_q;
   op_info_t          info_q;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] start_q;
   logic              take;
   logic              first;

   always_comb begin
      take     = in_valid && in_ready;
      first    = (phase_q == '0);
      cmp_info = first ? dec_info : info_q;
      cmp_op   = first ? in_byte  : op_q;
      cmp_addr = first ? pc_q     : start_q;
      cmp_lo   = (phase_q == PH_W'(2)) ? lo_q    : in_byte;
      cmp_hi   = (phase_q == PH_W'(2)) ? in_byte : 8'h00;
      done     = take && ((phase_q + PH_W'(1)) == cmp_info.len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         op_q    <= '0;
         lo_q    <= '0;
         info_q  <= '0;
         pc_q    <= RESET_ADDR;
         start_q <= RESET_ADDR;
      end else if (flush) begin
         phase_q <= '0;
         pc_q    <= flush_addr;
      end else if (take) begin
         pc_q <= pc_q + ADDR_W'(1);
         if (done) phase_q <= '0;
         else      phase_q <= phase_q + PH_W'(1);
         if (first) begin
            op_q    <= in_byte;
            info_q  <= dec_info;
            start_q <= pc_q;
         end
         if (phase_q == PH_W'(1)) lo_q <= in_byte;
      end
   end

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != '0) |-> (phase_q < info_q.len)); // R2

endmodule

// File: rtl/vfd_fetch_decode.sv
module vfd_fetch_decode
   import vfd_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                OPW        = 16,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_addr,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_opcode,
   output logic [2:0]        out_class,
   output logic [1:0]        out_len,
   output logic              out_illegal,
   output logic [OPW-1:0]    out_operand,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int WORD_W = 16;

   generate
      if (OPW < WORD_W) begin : g_bad_opw
         $error("OPW must be at least 16");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   op_info_t          dec_info;
   op_info_t          cmp_info;
   logic              done;
   logic [7:0]        cmp_op;
   logic [7:0]        cmp_lo;
   logic [7:0]        cmp_hi;
   logic [ADDR_W-1:0] cmp_addr;
   logic [OPW-1:0]    cmp_val;
   instr_cls_e        cls_q;

   assign in_ready = !flush && (!out_valid || out_ready);

   vfd_opdecode u_dec (
      .op   (in_byte),
      .info (dec_info)
   );

   vfd_collect #(
      .ADDR_W     (ADDR_W),
      .RESET_ADDR (RESET_ADDR)
   ) u_col (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .flush_addr (flush_addr),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_byte    (in_byte),
      .dec_info   (dec_info),
      .done       (done),
      .cmp_op     (cmp_op),
      .cmp_info   (cmp_info),
      .cmp_lo     (cmp_lo),
      .cmp_hi     (cmp_hi),
      .cmp_addr   (cmp_addr)
   );

   vfd_imm_ext #(.OPW(OPW)) u_ext (
      .cls (cmp_info.cls),
      .op  (cmp_op),
      .lo  (cmp_lo),
      .hi  (cmp_hi),
      .val (cmp_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_opcode  <= '0;
         cls_q       <= CL_NONE;
         out_len     <= '0;
         out_illegal <= 1'b0;
         out_operand <= '0;
         out_addr    <= RESET_ADDR;
      end else if (flush) begin
         out_valid <= 1'b0;
      end else if (done) begin
         out_valid   <= 1'b1;
         out_opcode  <= cmp_op;
         cls_q       <= cmp_info.cls;
         out_len     <= cmp_info.len;
         out_illegal <= (cmp_info.cls == CL_ILLEGAL);
         out_operand <= cmp_val;
         out_addr    <= cmp_addr;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign out_class = cls_q;

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_operand)
         && $stable(out_addr) && $stable(out_opcode))); // R9
   AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid); // R10
   AST_ILLEGAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_len == 2'd1 && out_operand == '0)); // R7
   AST_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_len == 2'd3) == (cls_q == CL_WORD))); // R2
   AST_ZX_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls_q == CL_BYTE_ZX) |-> (out_operand[OPW-1:8] == '0)); // R4
   AST_QUICK_SX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cls_q == CL_QUICK_SX) |->
         ((&out_operand[OPW-1:3]) || !(|out_operand[OPW-1:3]))); // R5

endmodule

// File: tb/vfd_fetch_decode_bench.sv
module vfd_fetch_decode_bench;

   localparam int AW = 16;
   localparam int OW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [AW-1:0] flush_addr = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_byte = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [7:0]    out_opcode;
   logic [2:0]    out_class;
   logic [1:0]    out_len;
   logic          out_illegal;
   logic [OW-1:0] out_operand;
   logic [AW-1:0] out_addr;

   int            checks = 0;
   int            errors = 0;
   logic [AW-1:0] exp_pc = '0;

   always #2 clk = ~clk;

   vfd_fetch_decode u_vfd_fetch_decode (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
      .out_class(out_class), .out_len(out_len), .out_illegal(out_illegal),
      .out_operand(out_operand), .out_addr(out_addr)
   );

   // {opcode, byte2, byte3, len, class, operand}
   localparam logic [55:0] VEC [10] = '{
      {8'h02, 8'h34, 8'h12, 8'd3, 8'd1, 16'h1234},
      {8'h17, 8'h80, 8'h00, 8'd2, 8'd3, 16'hFF80},
      {8'h11, 8'h80, 8'h00, 8'd2, 8'd2, 16'h0080},
      {8'h2E, 8'h7F, 8'h00, 8'd2, 8'd2, 16'h007F},
      {8'hAF, 8'h00, 8'h00, 8'd1, 8'd4, 16'h000F},
      {8'hC8, 8'h00, 8'h00, 8'd1, 8'd5, 16'hFFF8},
      {8'hD7, 8'h00, 8'h00, 8'd1, 8'd5, 16'h0007},
      {8'hFB, 8'h9C, 8'h00, 8'd2, 8'd3, 16'hFF9C},
      {8'hF4, 8'hCD, 8'hAB, 8'd3, 8'd1, 16'hABCD},
      {8'h50, 8'h00, 8'h00, 8'd1, 8'd7, 16'h0000}
   };

   function automatic int ref_len(input logic [7:0] op);
      case (op) inside
         [8'h02:8'h05], [8'h49:8'h4E], 8'h5A, 8'h5B: return 3;
         8'h2E, 8'h2F, [8'h52:8'h54]:                return 2;
         [8'h10:8'h2B], [8'h5C:8'h6D], [8'hF4:8'hFD]: return op[0] ? 2 : 3;
         default:                                    return 1;
      endcase
   endfunction

   function automatic int ref_cls(input logic [7:0] op);
      case (op) inside
         [8'h02:8'h05], [8'h49:8'h4E], 8'h5A, 8'h5B: return 1;
         8'h2E, 8'h2F, [8'h52:8'h54]:                return 2;
         [8'h10:8'h2B], [8'h5C:8'h6D], [8'hF4:8'hFD]: begin
            if (!op[0]) return 1;
            if (op inside {[8'h17:8'h21], 8'hF9, 8'hFB, 8'hFD}) return 3;
            return 2;
         end
         [8'hA0:8'hBF]: return 4;
         [8'hC0:8'hEF]: return 5;
         8'h50, 8'h51, [8'h7A:8'h9F], [8'hF0:8'hF3], 8'hFE, 8'hFF: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] ref_val(input logic [7:0] op, input logic [7:0] b1,
                                           input logic [7:0] b2);
      case (ref_cls(op))
         1:       return {b2, b1};
         2:       return {8'h00, b1};
         3:       return {{8{b1[7]}}, b1};
         4:       return {12'h000, op[3:0]};
         5:       return {{12{op[3]}}, op[3:0]};
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string tag_of(input int cls);
      case (cls)
         0:       return "R6";
         1:       return "R3";
         2, 3:    return "R4";
         4, 5:    return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Entered just after a negedge; returns just after a negedge.
   task automatic drive_bytes(input int n, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input bit gaps);
      logic [7:0] seq [3];
      seq = '{b0, b1, b2};
      for (int i = 0; i < n; i++) begin
         if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
         in_valid = 1'b1;
         in_byte  = seq[i];
         #0;
         while (!in_ready) @(negedge clk);
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic collect_check(input logic [7:0] op, input int e_len, input int e_cls,
                                input logic [15:0] e_val, input string atag);
      int waitc = 0;
      repeat ($urandom_range(0, 4)) @(negedge clk);
      out_ready = 1'b1;
      while (!out_valid && waitc < 100) begin
         @(negedge clk);
         waitc++;
      end
      check("R2", "out_valid", 32'(out_valid), 32'd1);
      check("R11", "opcode", 32'(out_opcode), 32'(op));
      check("R2", "length", 32'(out_len), 32'(e_len));
      check(tag_of(e_cls), "class", 32'(out_class), 32'(e_cls));
      check(tag_of(e_cls), "operand", 32'(out_operand), 32'(e_val));
      check("R7", "illegal", 32'(out_illegal), 32'(e_cls == 7));
      check(atag, "address", 32'(out_addr), 32'(exp_pc));
      @(negedge clk);
      out_ready = 1'b0;
      exp_pc = exp_pc + AW'(e_len);
   endtask

   task automatic run_instr(input logic [7:0] op, input logic [7:0] b1,
                            input logic [7:0] b2, input string atag);
      fork
         drive_bytes(ref_len(op), op, b1, b2, 1'b1);
         collect_check(op, ref_len(op), ref_cls(op), ref_val(op, b1, b2), atag);
      join
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "reset out_valid", 32'(out_valid), 32'd0);
      check("R1", "reset in_ready", 32'(in_ready), 32'd1);
      @(negedge clk);

      // vector table: first entry also proves the reset start address (R1)
      for (int i = 0; i < 10; i++) begin
         fork
            drive_bytes(int'(VEC[i][31:24]), VEC[i][55:48], VEC[i][47:40],
                        VEC[i][39:32], 1'b1);
            collect_check(VEC[i][55:48], int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                          VEC[i][15:0], (i == 0) ? "R1" : "R8");
         join
      end

      // every opcode against the reference rules, random gaps and stalls
      for (int op = 0; op < 256; op++)
         run_instr(8'(op), 8'($urandom), 8'($urandom), "R8");

      // R9: back-pressure holds the output and blocks the next byte
      a = exp_pc;
      out_ready = 1'b0;
      drive_bytes(3, 8'h49, 8'h11, 8'h22, 1'b0);
      @(negedge clk);
      check("R9", "held valid", 32'(out_valid), 32'd1);
      in_valid = 1'b1;
      in_byte  = 8'h01;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R9", "in_ready while stalled", 32'(in_ready), 32'd0);
         check("R9", "held operand", 32'(out_operand), 32'h2211);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", "next opcode after release", 32'(out_opcode), 32'h01);
      check("R8", "next address after release", 32'(out_addr), 32'(a + AW'(3)));
      @(negedge clk);
      check("R9", "valid drops once taken", 32'(out_valid), 32'd0);
      out_ready = 1'b0;
      exp_pc = a + AW'(4);

      // R10: flush in the middle of a 3-byte instruction
      drive_bytes(2, 8'h02, 8'h55, 8'h00, 1'b0);
      flush      = 1'b1;
      flush_addr = 16'h1234;
      #1;
      check("R10", "in_ready during flush", 32'(in_ready), 32'd0);
      @(negedge clk);
      flush = 1'b0;
      repeat (3) @(negedge clk);
      check("R10", "no output from partial", 32'(out_valid), 32'd0);
      exp_pc = 16'h1234;
      run_instr(8'h01, 8'h00, 8'h00, "R10");

      // R10: flush drops a finished but unaccepted instruction
      drive_bytes(1, 8'h00, 8'h00, 8'h00, 1'b0);
      check("R10", "pending before flush", 32'(out_valid), 32'd1);
      flush      = 1'b1;
      flush_addr = 16'hFFFF;
      @(negedge clk);
      flush = 1'b0;
      check("R10", "pending dropped", 32'(out_valid), 32'd0);
      exp_pc = 16'hFFFF;

      // R8: address wraps past the top
      run_instr(8'h5A, 8'h78, 8'h56, "R8");
      run_instr(8'hA3, 8'h00, 8'h00, "R8");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule